// File: doc/BRIEF.md
# Port Identifier Control-Word Inserter and Collector

This block places an 8-byte link-endpoint identifier into one reserved control-word subchannel of a radio fronthaul link. It also recovers the identifier that the far end sends. The identifier has three parts: the node's 48-bit Ethernet MAC address, an 8-bit port number and one reserved byte that is always zero. These bytes are spread over the four control words of the subchannel in each hyperframe, using two bytes of each word. Bytes are only sent once the link reports that it is synchronised and the configured port number is legal.

The transmit side reads the current basic-frame position: subchannel index, repetition index and byte index within the control word. One clock later it returns the byte for that position, together with a flag that marks positions in the identifier's subchannel. The receive side watches the incoming control-word bytes and rebuilds the far-end identifier over one hyperframe. When all four control words of a hyperframe have arrived, it pulses a capture strobe. A second strobe marks a capture whose MAC address or port number differs from the previous one. Upper layers can use these strobes for topology discovery.

Top module: `port_id_cw`

## Requirements
- R1: The slot number is s = 4*Y[0] + Xs. In subchannel 52 with Y < 2, slot 0 carries the reserved byte, slot 1 carries `port_num`, and slots 2 to 7 carry MAC bytes 0 to 5, where MAC byte i is `mac_addr[8i+7:8i]`. `tx_byte` shows the byte one clock after the position is presented.
- R2: For any subchannel index other than 52, `tx_byte` is zero. `tx_sc_hit` is high, one clock after the position, exactly when the subchannel index is 52.
- R3: Bytes with Y greater than 1 are always sent as zero.
- R4: The reserved byte (Y = 0, Xs = 0) is always sent as zero.
- R5: While `link_sync` is low, every byte sent is zero.
- R6: When `port_num` is 0, `cfg_err` is high one clock later and every byte sent is zero. `cfg_err` is low for any nonzero port number.
- R7: On receive, a valid byte at subchannel 0 with Xs = 0 starts a new hyperframe and discards partial progress. One clock after the byte that completes all eight slots, `id_valid` pulses for one cycle. In that same cycle `rx_mac` and `rx_port` show the rebuilt identifier, using the same slot layout as R1.
- R8: A hyperframe in which any slot is missing produces no `id_valid` pulse, and `rx_mac` and `rx_port` keep their previous values.
- R9: On receive, the content of the reserved byte and of bytes with Y greater than 1 has no effect on `rx_mac` or `rx_port`.
- R10: `id_changed` pulses together with `id_valid` when the new capture differs from the previous capture in MAC address or port number. It does not pulse on the first capture after reset.
- R11: While reset is held and after it is released, `tx_byte`, `tx_sc_hit`, `cfg_err`, `rx_mac`, `rx_port`, `id_valid` and `id_changed` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mac_addr | input | 48 | Local MAC address; byte i is bits 8i+7:8i |
| port_num | input | 8 | Local port number, legal values 1..255 |
| link_sync | input | 1 | Link layer 1/2 synchronisation reached |
| tx_ns | input | 6 | Transmit subchannel index |
| tx_xs | input | 2 | Transmit repetition index within the hyperframe |
| tx_y | input | Y_W | Transmit byte index within the control word |
| tx_byte | output | 8 | Byte to place at the presented position (one clock later) |
| tx_sc_hit | output | 1 | Position belonged to the identifier subchannel |
| cfg_err | output | 1 | Configured port number is illegal (zero) |
| rx_vld | input | 1 | Receive byte strobe |
| rx_ns | input | 6 | Receive subchannel index |
| rx_xs | input | 2 | Receive repetition index |
| rx_y | input | Y_W | Receive byte index within the control word |
| rx_byte | input | 8 | Received control-word byte |
| rx_mac | output | 48 | Last captured far-end MAC address |
| rx_port | output | 8 | Last captured far-end port number |
| id_valid | output | 1 | One-cycle pulse: complete identifier captured |
| id_changed | output | 1 | One-cycle pulse: capture differs from the previous one |

## Verification
A transmit slot mapped to the wrong byte would show up at the very next clock as a mismatch on `tx_byte`, for that one (Xs, Y) position. The same fault would hit every hyperframe in the same way. A gating fault on the sync, port-zero, reserved-byte or high-Y conditions would make a nonzero byte leak out one clock after the offending position. On receive, a stale or wrongly cleared slot mask shows up within one hyperframe, in one of two ways. Either a pulse is missing after a complete set of words, or a pulse appears after an incomplete set. A faulty comparison register shows up at the second capture as a wrong `id_changed` value.

// File: rtl/pid_pkg.sv
package pid_pkg;

    localparam int NS_W     = 6;
    localparam int XS_W     = 2;
    localparam int SUBCH    = 52;
    localparam int ID_BYTES = 8;
    localparam int SLOT_W   = $clog2(ID_BYTES);
    localparam int MAC_W    = 48;
    localparam int MAC_B    = MAC_W / 8;

    typedef struct packed {
        logic [MAC_W-1:0] mac;
        logic [7:0]       port;
    } pid_t;

    // slot = {Y[0], Xs}; 0 reserved, 1 port, 2..7 MAC bytes 0..5
    function automatic logic [SLOT_W-1:0] pid_slot(input logic y0, input logic [XS_W-1:0] xs);
        return {y0, xs};
    endfunction

    function automatic logic [7:0] pid_slot_byte(input pid_t id, input logic [SLOT_W-1:0] s);
        logic [7:0] b;
        case (s)
            3'd0:    b = 8'h00;
            3'd1:    b = id.port;
            3'd2:    b = id.mac[7:0];
            3'd3:    b = id.mac[15:8];
            3'd4:    b = id.mac[23:16];
            3'd5:    b = id.mac[31:24];
            3'd6:    b = id.mac[39:32];
            default: b = id.mac[47:40];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pid_tx_map.sv
module pid_tx_map
    import pid_pkg::*;
#(
    parameter int Y_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  pid_t            id,
    input  logic            sync,
    input  logic [NS_W-1:0] ns,
    input  logic [XS_W-1:0] xs,
    input  logic [Y_W-1:0]  y,
    output logic [7:0]      byte_o,
    output logic            hit_o,
    output logic            err_o
);
    logic sc_hit, port_bad, y_ok, send;

    always_comb begin
        sc_hit   = (ns == NS_W'(SUBCH));
        port_bad = (id.port == 8'h00);
        y_ok     = (y < Y_W'(2));
        send     = sc_hit && sync && !port_bad && y_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o <= '0;
            hit_o  <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            hit_o  <= sc_hit;
            err_o  <= port_bad;
            byte_o <= send ? pid_slot_byte(id, pid_slot(y[0], xs)) : 8'h00;
        end
    end
endmodule

// File: rtl/pid_rx_collect.sv
module pid_rx_collect
    import pid_pkg::*;
#(
    parameter int Y_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vld,
    input  logic [NS_W-1:0] ns,
    input  logic [XS_W-1:0] xs,
    input  logic [Y_W-1:0]  y,
    input  logic [7:0]      din,
    output logic            done,
    output pid_t            asm_id
);
    localparam logic [ID_BYTES-1:0] FULL = '1;

    logic [ID_BYTES-1:0] mask_q, mask_n;
    logic [7:0]          sh_q [ID_BYTES];
    logic [7:0]          sh_n [ID_BYTES];
    logic                hit, hf_start;
    logic [SLOT_W-1:0]   slot;

    always_comb begin
        hit      = vld && (ns == NS_W'(SUBCH)) && (y < Y_W'(2));
        hf_start = vld && (ns == '0) && (xs == '0);
        slot     = pid_slot(y[0], xs);
        mask_n   = hf_start ? '0 : mask_q;
        sh_n     = sh_q;
        if (hit) begin
            mask_n[slot] = 1'b1;
            sh_n[slot]   = din;
        end
        done = hit && (mask_n == FULL) && (mask_q != FULL);
        asm_id.port = sh_n[1];
        for (int i = 0; i < MAC_B; i++) begin
            asm_id.mac[8*i +: 8] = sh_n[2+i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            for (int i = 0; i < ID_BYTES; i++) sh_q[i] <= 8'h00;
        end else begin
            mask_q <= mask_n;
            sh_q   <= sh_n;
        end
    end
endmodule

// File: rtl/pid_rx_track.sv
module pid_rx_track
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  pid_t asm_id,
    output pid_t cap_o,
    output logic valid_o,
    output logic changed_o
);
    logic have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o     <= '0;
            valid_o   <= 1'b0;
            changed_o <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            valid_o   <= done;
            changed_o <= done && have_prev && (asm_id != cap_o);
            if (done) begin
                cap_o     <= asm_id;
                have_prev <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/port_id_cw.sv
module port_id_cw
    import pid_pkg::*;
#(
    parameter int Y_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [47:0]      mac_addr,
    input  logic [7:0]       port_num,
    input  logic             link_sync,
    input  logic [5:0]       tx_ns,
    input  logic [1:0]       tx_xs,
    input  logic [Y_W-1:0]   tx_y,
    output logic [7:0]       tx_byte,
    output logic             tx_sc_hit,
    output logic             cfg_err,
    input  logic             rx_vld,
    input  logic [5:0]       rx_ns,
    input  logic [1:0]       rx_xs,
    input  logic [Y_W-1:0]   rx_y,
    input  logic [7:0]       rx_byte,
    output logic [47:0]      rx_mac,
    output logic [7:0]       rx_port,
    output logic             id_valid,
    output logic             id_changed
);
    pid_t local_id, asm_id, cap_id;
    logic done;

    assign local_id.mac  = mac_addr;
    assign local_id.port = port_num;

    pid_tx_map #(.Y_W(Y_W)) u_tx (
        .clk(clk), .rst(rst), .id(local_id), .sync(link_sync),
        .ns(tx_ns), .xs(tx_xs), .y(tx_y),
        .byte_o(tx_byte), .hit_o(tx_sc_hit), .err_o(cfg_err)
    );

    pid_rx_collect #(.Y_W(Y_W)) u_col (
        .clk(clk), .rst(rst), .vld(rx_vld), .ns(rx_ns), .xs(rx_xs),
        .y(rx_y), .din(rx_byte), .done(done), .asm_id(asm_id)
    );

    pid_rx_track u_trk (
        .clk(clk), .rst(rst), .done(done), .asm_id(asm_id),
        .cap_o(cap_id), .valid_o(id_valid), .changed_o(id_changed)
    );

    assign rx_mac  = cap_id.mac;
    assign rx_port = cap_id.port;
endmodule

// File: rtl/port_id_cw_chk.sv
module port_id_cw_chk #(
    parameter int Y_W = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [7:0]     port_num,
    input logic           link_sync,
    input logic [5:0]     tx_ns,
    input logic [1:0]     tx_xs,
    input logic [Y_W-1:0] tx_y,
    input logic [7:0]     tx_byte,
    input logic           tx_sc_hit,
    input logic           cfg_err,
    input logic [47:0]    rx_mac,
    input logic [7:0]     rx_port,
    input logic           id_valid,
    input logic           id_changed
);
    p_other_sc_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_ns != 6'd52) |=> (tx_byte == 8'h00 && !tx_sc_hit));

    p_high_y_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_y > Y_W'(1)) |=> (tx_byte == 8'h00));

    p_rsv_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_y == '0 && tx_xs == 2'd0) |=> (tx_byte == 8'h00));

    p_unsync_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!link_sync) |=> (tx_byte == 8'h00));

    p_port_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (port_num == 8'h00) |=> (cfg_err && tx_byte == 8'h00));

    p_pulse_once_r7: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> !id_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> ($stable(rx_mac) && $stable(rx_port)));

    p_chg_with_valid_r10: assert property (@(posedge clk) disable iff (rst)
        id_changed |-> id_valid);
endmodule

bind port_id_cw port_id_cw_chk #(.Y_W(Y_W)) u_chk (.*);

// File: tb/sim_port_id_cw.sv
module sim_port_id_cw;
    localparam int CLK_P = 10;
    localparam int YW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [47:0]   mac_addr;
    logic [7:0]    port_num;
    logic          link_sync;
    logic [5:0]    tx_ns;
    logic [1:0]    tx_xs;
    logic [YW-1:0] tx_y;
    logic [7:0]    tx_byte;
    logic          tx_sc_hit, cfg_err;
    logic          rx_vld;
    logic [5:0]    rx_ns;
    logic [1:0]    rx_xs;
    logic [YW-1:0] rx_y;
    logic [7:0]    rx_byte;
    logic [47:0]   rx_mac;
    logic [7:0]    rx_port;
    logic          id_valid, id_changed;

    int checks = 0;
    int fails  = 0;
    int nv, nc;

    always #(CLK_P/2) clk = ~clk;

    port_id_cw #(.Y_W(YW)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx(input logic [47:0] m, input logic [7:0] p,
                                          input logic s, input int ns, input int xs, input int y);
        int sl;
        if (ns != 52 || !s || p == 0 || y > 1) return 8'h00;
        sl = (y % 2) * 4 + xs;
        if (sl == 0) return 8'h00;
        if (sl == 1) return p;
        return m[8*(sl-2) +: 8];
    endfunction

    function automatic logic [7:0] slot_val(input logic [47:0] m, input logic [7:0] p, input int sl);
        if (sl == 0) return 8'hA5;
        if (sl == 1) return p;
        return m[8*(sl-2) +: 8];
    endfunction

    task automatic rx_put(input int ns, input int xs, input int y, input logic [7:0] b);
        rx_vld = 1'b1; rx_ns = 6'(ns); rx_xs = 2'(xs); rx_y = YW'(y); rx_byte = b;
        @(negedge clk);
        rx_vld = 1'b0;
        if (id_valid) nv++;
        if (id_changed) nc++;
    endtask

    // skip_xs: repetition index to leave out (4 = none)
    task automatic send_hf(input logic [47:0] m, input logic [7:0] p, input int skip_xs);
        nv = 0; nc = 0;
        rx_put(0, 0, 0, 8'h3C);
        for (int xs = 0; xs < 4; xs++) begin
            if (xs != skip_xs) begin
                rx_put(52, xs, 2, 8'($urandom));
                rx_put(52, xs, 1, slot_val(m, p, 4 + xs));
                rx_put(52, xs, 0, slot_val(m, p, xs));
            end
        end
        rx_put(10, 1, 0, 8'h77);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] m1, m2;
        logic [7:0]  e;
        string       tag;
        void'($urandom(32'd1234));
        rst = 1'b1; mac_addr = 48'h0; port_num = 8'h0; link_sync = 1'b0;
        tx_ns = 6'd0; tx_xs = 2'd0; tx_y = '0;
        rx_vld = 1'b0; rx_ns = 6'd0; rx_xs = 2'd0; rx_y = '0; rx_byte = 8'h0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 tx_byte", 64'(tx_byte), 0);
        chk("R11 flags", 64'({tx_sc_hit, cfg_err, id_valid, id_changed}), 0);
        chk("R11 rx_mac", 64'(rx_mac), 0);
        chk("R11 rx_port", 64'(rx_port), 0);
        rst = 1'b0;
        @(negedge clk);

        // Directed transmit layout, R1
        mac_addr = 48'h665544332211; port_num = 8'h07; link_sync = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tx_ns = 6'd52; tx_xs = 2'(k % 4); tx_y = YW'(k / 4);
            @(negedge clk);
            e = (k == 0) ? 8'h00 : (k == 1) ? 8'h07 : 8'(k - 1) * 8'h11;
            chk(k == 0 ? "R4 reserved slot" : "R1 slot layout", 64'(tx_byte), 64'(e));
            chk("R2 hit", 64'(tx_sc_hit), 1);
        end
        // R6 port zero
        port_num = 8'h00; tx_ns = 6'd52; tx_xs = 2'd1; tx_y = '0;
        @(negedge clk);
        chk("R6 cfg_err", 64'(cfg_err), 1);
        chk("R6 zero byte", 64'(tx_byte), 0);
        port_num = 8'h01;
        @(negedge clk);
        chk("R6 cfg_err clear", 64'(cfg_err), 0);

        // Random transmit patterns
        for (int it = 0; it < 600; it++) begin
            int ns, xs, y;
            if (it % 60 == 0) mac_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            port_num  = ($urandom % 10 == 0) ? 8'h00 : 8'($urandom);
            link_sync = ($urandom % 5 != 0);
            ns = ($urandom % 2 == 0) ? 52 : int'($urandom % 64);
            xs = int'($urandom % 4);
            y  = int'($urandom % 4);
            tx_ns = 6'(ns); tx_xs = 2'(xs); tx_y = YW'(y);
            @(negedge clk);
            e = exp_tx(mac_addr, port_num, link_sync, ns, xs, y);
            if (ns != 52) tag = "R2 other subchannel";
            else if (!link_sync) tag = "R5 unsynchronised";
            else if (port_num == 0) tag = "R6 port zero";
            else if (y > 1) tag = "R3 high Y";
            else if (y == 0 && xs == 0) tag = "R4 reserved";
            else tag = "R1 random layout";
            chk(tag, 64'(tx_byte), 64'(e));
            chk("R2 hit flag", 64'(tx_sc_hit), 64'(ns == 52));
            chk("R6 err flag", 64'(cfg_err), 64'(port_num == 0));
        end

        // Receive path
        m1 = 48'hC0FFEE123456; m2 = 48'hC0FFEE123457;
        send_hf(m1, 8'h09, 4);
        chk("R7 first pulse", 64'(nv), 1);
        chk("R10 no change on first", 64'(nc), 0);
        chk("R7 rx_mac", 64'(rx_mac), 64'(m1));
        chk("R9 rx_port ignores reserved", 64'(rx_port), 64'h09);
        send_hf(m1, 8'h09, 4);
        chk("R7 repeat pulse", 64'(nv), 1);
        chk("R10 same id no change", 64'(nc), 0);
        send_hf(m2, 8'h09, 2);
        chk("R8 incomplete no pulse", 64'(nv), 0);
        chk("R8 mac held", 64'(rx_mac), 64'(m1));
        send_hf(m2, 8'h09, 4);
        chk("R10 mac change", 64'(nc), 1);
        chk("R7 new mac", 64'(rx_mac), 64'(m2));
        send_hf(m2, 8'h0A, 4);
        chk("R10 port change", 64'(nc), 1);
        chk("R7 new port", 64'(rx_port), 64'h0A);
        for (int it = 0; it < 20; it++) begin
            logic [47:0] mr;
            logic [7:0]  pr;
            logic [47:0] pm;
            logic [7:0]  pp;
            pm = rx_mac; pp = rx_port;
            mr = ($urandom % 2 == 0) ? pm : ({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
            pr = 8'($urandom % 255 + 1);
            send_hf(mr, pr, 4);
            chk("R7 random pulse", 64'(nv), 1);
            chk("R9 random mac", 64'(rx_mac), 64'(mr));
            chk("R10 random change", 64'(nc), 64'((mr != pm) || (pr != pp)));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule